// File: doc/BRIEF.md
# Cascaded Classifier Window Evaluator

This block decides whether one detection window is kept or thrown away. It walks a list of classifier stages in a fixed order. For each stage it adds up a stream of signed feature responses supplied from outside. It then compares that total against the stage's own pair of bounds, which it reads from an internal parameter memory. The first stage whose total falls outside its bounds ends the evaluation and rejects the window. Later stages are not looked at and their features are not consumed.

A window is kept only when every stage passes. The index of a kept window is appended to an on-chip result list at the position held by an incrementing write pointer. Window indices come from an internal counter that advances on every start that is taken. A surrounding controller loads the stage parameters, sets the stage count and pulses a start. It then feeds features whenever the block asks for them and waits for the done pulse. Extracting features from an integral image and merging neighbouring detections are left to other blocks.

Top module: `cls_cascade_eval`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, feat_ready_o and res_ovf_o are 0, res_count_o is 0 and win_idx_o is 0.
- R2: The response of a stage is the wrapping two's-complement sum of exactly its feature-count values. Values are taken on cycles where feat_ready_o and feat_valid_i are both 1. The stage parameter word holds the lower bound in bits [RESP_W-1:0], the upper bound in bits [2*RESP_W-1:RESP_W] and the feature count above them (for defaults: [15:0], [31:16], [37:32]).
- R3: A stage passes only if lower <= response <= upper, compared as signed values, with both ends inclusive.
- R4: Stages are evaluated in order 0 to N-1, where N is num_stages_i sampled at start. On the first failing stage the window is rejected and no further features are consumed.
- R5: A window is accepted only if all N stages pass. done_o is a one-cycle pulse carrying the decision on accept_o, and busy_o is 0 in that cycle. When features are offered every cycle, done_o rises 1 + sum(3 + n_i) cycles after the cycle in which start was sampled, where the sum runs over the evaluated stages and n_i is each one's feature count.
- R6: With N = 0 the window is accepted with no features consumed, and done_o rises in the cycle after start is sampled.
- R7: win_idx_o shows the index of the most recently started window. The k-th start taken since reset evaluates window k-1.
- R8: A start while busy is ignored: the running evaluation, its latency and win_idx_o are unaffected.
- R9: An accepted window's index is written at list position res_count_o, and res_count_o increments on the edge where done_o rises. Entry res_raddr_i appears on res_rdata_o one cycle later.
- R10: When the list already holds RES_DEPTH entries, further accepted indices are dropped, res_count_o stays at RES_DEPTH and res_ovf_o becomes 1 until reset.
- R11: A stage with a feature count of 0 consumes nothing and has a response of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start evaluating the next window |
| num_stages_i | input | $clog2(MAX_STAGES+1) | Stage count, 0 to MAX_STAGES |
| prm_we_i | input | 1 | Stage parameter write enable |
| prm_waddr_i | input | $clog2(MAX_STAGES) | Stage parameter write address |
| prm_wdata_i | input | CNT_W+2*RESP_W | Stage parameter word {count, upper, lower} |
| feat_valid_i | input | 1 | Feature value offered |
| feat_val_i | input | RESP_W | Signed feature response |
| feat_ready_o | output | 1 | Block takes a feature this cycle |
| busy_o | output | 1 | Evaluation in progress |
| win_idx_o | output | WIN_W | Index of most recently started window |
| done_o | output | 1 | One-cycle decision pulse |
| accept_o | output | 1 | Decision: 1 accepted, 0 rejected |
| res_raddr_i | input | $clog2(RES_DEPTH) | Result list read address |
| res_rdata_o | output | WIN_W | Result list entry, one cycle after address |
| res_count_o | output | $clog2(RES_DEPTH+1) | Number of stored entries |
| res_ovf_o | output | 1 | Sticky list-full drop flag |

## Verification
The properties assume three things about the inputs. Stage parameters are not rewritten while a window is running. num_stages_i never exceeds MAX_STAGES. Feature sums stay inside the RESP_W range, so wrapping never changes a decision. The stimulus writes all parameters before any start and uses stage counts up to four. Its feature values stay within a few hundred. It places starts one cycle after the previous done at the earliest, with one deliberate start issued mid-evaluation to probe the ignore rule.

// File: rtl/cls_pkg.sv
package cls_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_ACC,
    ST_CHECK
  } seq_state_t;
endpackage

// File: rtl/cls_stage_mem.sv
module cls_stage_mem #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 38
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cls_result_list.sv
module cls_result_list #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4,
  parameter int DW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] pdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic          room;
  logic          wr_en;

  assign room  = (count < FULL);
  assign wr_en = push && room && !rst;

  always_ff @(posedge clk) begin
    if (wr_en) mem[count[AW-1:0]] <= pdata;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      if (room) count <= count + CW'(1);
      else      ovf   <= 1'b1;
    end
  end
endmodule

// File: rtl/cls_seq.sv
module cls_seq
  import cls_pkg::*;
#(
  parameter int MAX_STAGES = 16,
  parameter int SW         = 4,
  parameter int NW         = 5,
  parameter int CNT_W      = 6,
  parameter int RESP_W     = 16,
  parameter int WIN_W      = 12,
  parameter int PRM_W      = CNT_W + 2*RESP_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [NW-1:0]            num_stages_i,
  output logic [SW-1:0]            prm_raddr_o,
  input  logic [PRM_W-1:0]         prm_rdata_i,
  input  logic                     feat_valid_i,
  input  logic signed [RESP_W-1:0] feat_val_i,
  output logic                     feat_ready_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     accept_o,
  output logic [WIN_W-1:0]         win_idx_o,
  output logic                     push_o,
  output logic [WIN_W-1:0]         push_data_o
);
  seq_state_t               state_q;
  logic [SW-1:0]            stage_q;
  logic [NW-1:0]            num_q;
  logic [CNT_W-1:0]         rem_q;
  logic signed [RESP_W-1:0] acc_q, lo_q, hi_q;
  logic [WIN_W-1:0]         win_cnt_q, win_cur_q;
  logic                     done_q, accept_q;

  logic [CNT_W-1:0]         prm_cnt;
  logic signed [RESP_W-1:0] prm_lo, prm_hi;
  logic                     in_bounds, last_stage, idle_start, zero_run;

  assign prm_lo  = $signed(prm_rdata_i[RESP_W-1:0]);
  assign prm_hi  = $signed(prm_rdata_i[2*RESP_W-1:RESP_W]);
  assign prm_cnt = prm_rdata_i[PRM_W-1:2*RESP_W];

  assign in_bounds  = (acc_q >= lo_q) && (acc_q <= hi_q);
  assign last_stage = ((NW'(stage_q) + NW'(1)) == num_q);
  assign idle_start = (state_q == ST_IDLE) && start_i;
  assign zero_run   = idle_start && (num_stages_i == '0);

  assign prm_raddr_o  = stage_q;
  assign feat_ready_o = (state_q == ST_ACC);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign accept_o     = accept_q;
  assign win_idx_o    = win_cur_q;
  assign push_o       = zero_run ||
                        ((state_q == ST_CHECK) && in_bounds && last_stage);
  assign push_data_o  = (state_q == ST_IDLE) ? win_cnt_q : win_cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      stage_q   <= '0;
      num_q     <= '0;
      rem_q     <= '0;
      acc_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      win_cnt_q <= '0;
      win_cur_q <= '0;
      done_q    <= 1'b0;
      accept_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            win_cur_q <= win_cnt_q;
            win_cnt_q <= win_cnt_q + WIN_W'(1);
            num_q     <= num_stages_i;
            stage_q   <= '0;
            if (num_stages_i == '0) begin
              done_q   <= 1'b1;
              accept_q <= 1'b1;
            end else begin
              state_q <= ST_FETCH;
            end
          end
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          rem_q   <= prm_cnt;
          lo_q    <= prm_lo;
          hi_q    <= prm_hi;
          acc_q   <= '0;
          state_q <= (prm_cnt == '0) ? ST_CHECK : ST_ACC;
        end
        ST_ACC: begin
          if (feat_valid_i) begin
            acc_q <= acc_q + feat_val_i;
            rem_q <= rem_q - CNT_W'(1);
            if (rem_q == CNT_W'(1)) state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!in_bounds || last_stage) begin
            done_q   <= 1'b1;
            accept_q <= in_bounds;
            state_q  <= ST_IDLE;
          end else begin
            stage_q <= stage_q + SW'(1);
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cls_cascade_eval.sv
module cls_cascade_eval #(
  parameter int MAX_STAGES = 16,
  parameter int CNT_W      = 6,
  parameter int RESP_W     = 16,
  parameter int WIN_W      = 12,
  parameter int RES_DEPTH  = 8,
  localparam int SW    = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1,
  localparam int NW    = $clog2(MAX_STAGES + 1),
  localparam int PRM_W = CNT_W + 2*RESP_W,
  localparam int RAW   = (RES_DEPTH > 1) ? $clog2(RES_DEPTH) : 1,
  localparam int CW    = $clog2(RES_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [NW-1:0]            num_stages_i,
  input  logic                     prm_we_i,
  input  logic [SW-1:0]            prm_waddr_i,
  input  logic [PRM_W-1:0]         prm_wdata_i,
  input  logic                     feat_valid_i,
  input  logic signed [RESP_W-1:0] feat_val_i,
  output logic                     feat_ready_o,
  output logic                     busy_o,
  output logic [WIN_W-1:0]         win_idx_o,
  output logic                     done_o,
  output logic                     accept_o,
  input  logic [RAW-1:0]           res_raddr_i,
  output logic [WIN_W-1:0]         res_rdata_o,
  output logic [CW-1:0]            res_count_o,
  output logic                     res_ovf_o
);
  logic [SW-1:0]    prm_raddr;
  logic [PRM_W-1:0] prm_rdata;
  logic             push;
  logic [WIN_W-1:0] push_data;

  cls_stage_mem #(.DEPTH(MAX_STAGES), .AW(SW), .DW(PRM_W)) i_stage_mem (
    .clk   (clk),
    .we    (prm_we_i),
    .waddr (prm_waddr_i),
    .wdata (prm_wdata_i),
    .raddr (prm_raddr),
    .rdata (prm_rdata)
  );

  cls_seq #(
    .MAX_STAGES(MAX_STAGES), .SW(SW), .NW(NW), .CNT_W(CNT_W),
    .RESP_W(RESP_W), .WIN_W(WIN_W), .PRM_W(PRM_W)
  ) i_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .num_stages_i (num_stages_i),
    .prm_raddr_o  (prm_raddr),
    .prm_rdata_i  (prm_rdata),
    .feat_valid_i (feat_valid_i),
    .feat_val_i   (feat_val_i),
    .feat_ready_o (feat_ready_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .accept_o     (accept_o),
    .win_idx_o    (win_idx_o),
    .push_o       (push),
    .push_data_o  (push_data)
  );

  cls_result_list #(.DEPTH(RES_DEPTH), .AW(RAW), .CW(CW), .DW(WIN_W)) i_results (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pdata (push_data),
    .raddr (res_raddr_i),
    .rdata (res_rdata_o),
    .count (res_count_o),
    .ovf   (res_ovf_o)
  );
endmodule

// File: rtl/cls_cascade_chk.sv
module cls_cascade_chk #(
  parameter int WIN_W     = 12,
  parameter int RES_DEPTH = 8,
  parameter int CW        = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             feat_ready_o,
  input logic             done_o,
  input logic             accept_o,
  input logic [WIN_W-1:0] win_idx_o,
  input logic [CW-1:0]    res_count_o,
  input logic             res_ovf_o
);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    res_count_o <= CW'(RES_DEPTH));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    res_ovf_o |=> res_ovf_o);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R4
  feat_busy_chk: assert property (@(posedge clk) disable iff (rst)
    feat_ready_o |-> busy_o);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(win_idx_o));

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(win_idx_o) |-> $past(start_i && !busy_o));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_count_o) |-> (done_o && accept_o));
endmodule

bind cls_cascade_eval cls_cascade_chk #(
  .WIN_W(WIN_W), .RES_DEPTH(RES_DEPTH), .CW(CW)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .feat_ready_o (feat_ready_o),
  .done_o       (done_o),
  .accept_o     (accept_o),
  .win_idx_o    (win_idx_o),
  .res_count_o  (res_count_o),
  .res_ovf_o    (res_ovf_o)
);

// File: tb/test_cls_cascade_eval.sv
module test_cls_cascade_eval;
  localparam int DEPTH = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start_i = 1'b0;
  logic [4:0]         num_stages_i = '0;
  logic               prm_we_i = 1'b0;
  logic [3:0]         prm_waddr_i = '0;
  logic [37:0]        prm_wdata_i = '0;
  logic               feat_valid_i = 1'b0;
  logic signed [15:0] feat_val_i = '0;
  logic               feat_ready_o, busy_o, done_o, accept_o, res_ovf_o;
  logic [11:0]        win_idx_o, res_rdata_o;
  logic [2:0]         res_raddr_i = '0;
  logic [3:0]         res_count_o;

  cls_cascade_eval i_cls_cascade_eval (
    .clk(clk), .rst(rst), .start_i(start_i), .num_stages_i(num_stages_i),
    .prm_we_i(prm_we_i), .prm_waddr_i(prm_waddr_i), .prm_wdata_i(prm_wdata_i),
    .feat_valid_i(feat_valid_i), .feat_val_i(feat_val_i),
    .feat_ready_o(feat_ready_o), .busy_o(busy_o), .win_idx_o(win_idx_o),
    .done_o(done_o), .accept_o(accept_o), .res_raddr_i(res_raddr_i),
    .res_rdata_o(res_rdata_o), .res_count_o(res_count_o), .res_ovf_o(res_ovf_o)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int p_cnt[16], p_lo[16], p_hi[16];
  int stim_q[$];
  int drv_q[$];
  int consumed = 0;
  int win_model = 0;
  int exp_list[$];
  int model_cnt = 0;
  bit model_ovf = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // feature feeder: offers queued values every cycle, counts those taken
  always @(negedge clk) begin
    if (rst) begin
      feat_valid_i = 1'b0;
    end else begin
      feat_valid_i = (drv_q.size() > 0);
      feat_val_i   = feat_valid_i ? 16'(drv_q[0]) : 16'sd0;
      if (feat_valid_i && feat_ready_o) begin
        void'(drv_q.pop_front());
        consumed++;
      end
    end
  end

  // per-clock reference of the result list count and overflow (R9, R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o && accept_o) begin
        if (model_cnt < DEPTH) model_cnt++;
        else model_ovf = 1'b1;
      end
      chk(res_count_o == 4'(model_cnt), "R9 count", res_count_o, model_cnt);
      chk(res_ovf_o == model_ovf, "R10 overflow", res_ovf_o, model_ovf);
    end
  end

  task automatic write_prm(input int s, input int cnt, input int lo, input int hi);
    @(negedge clk);
    prm_we_i    = 1'b1;
    prm_waddr_i = 4'(s);
    prm_wdata_i = {6'(cnt), 16'(hi), 16'(lo)};
    p_cnt[s] = cnt; p_lo[s] = lo; p_hi[s] = hi;
    @(negedge clk);
    prm_we_i = 1'b0;
  endtask

  // R2 R3 R4 R5 R6 R7 R8 R11: one window against the behavioural expectation
  task automatic run_win(input int ns, input bit mid_start);
    int pos = 0, lat = 1, cyc = 0, exp_idx;
    bit ok = 1'b1;
    for (int s = 0; s < ns; s++) begin
      int sum = 0;
      for (int k = 0; k < p_cnt[s]; k++) begin
        sum += stim_q[pos];
        pos++;
      end
      lat += 3 + p_cnt[s];
      if (sum < p_lo[s] || sum > p_hi[s]) begin
        ok = 1'b0;
        break;
      end
    end
    @(negedge clk);
    drv_q = stim_q;
    consumed = 0;
    exp_idx = win_model;
    win_model++;
    start_i = 1'b1;
    num_stages_i = 5'(ns);
    do begin
      @(negedge clk);
      cyc++;
      start_i = (mid_start && cyc == 3);
    end while (!done_o && cyc < 2000);
    chk(done_o == 1'b1, "R5 done seen", done_o, 1);
    chk(cyc == lat, "R5 latency", cyc, lat);
    chk(accept_o == ok, "R5 accept flag", accept_o, ok);
    chk(busy_o == 1'b0, "R5 idle at done", busy_o, 0);
    chk(win_idx_o == 12'(exp_idx), "R7 window index", win_idx_o, exp_idx);
    if (ok) exp_list.push_back(exp_idx);
    @(negedge clk);
    chk(done_o == 1'b0, "R5 single pulse", done_o, 0);
    @(negedge clk);
    chk(consumed == pos, "R4 features consumed", consumed, pos);
    drv_q.delete();
    stim_q.delete();
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(done_o == 0, "R1 done", done_o, 0);
    chk(feat_ready_o == 0, "R1 ready", feat_ready_o, 0);
    chk(res_count_o == 0, "R1 count", res_count_o, 0);
    chk(res_ovf_o == 0, "R1 ovf", res_ovf_o, 0);
    chk(win_idx_o == 0, "R1 index", win_idx_o, 0);

    write_prm(0, 3, -10, 20);
    write_prm(1, 2, 5, 5);
    write_prm(2, 0, -1, 0);   // R11 zero-feature stage
    write_prm(3, 1, 0, 100);

    // R3 inclusive bounds on every stage: accepted
    stim_q = '{5, -3, 8, 2, 3, 100};
    run_win(4, 1'b0);
    // R4 stage 1 fails above upper bound; stage 3 feature not taken
    stim_q = '{20, 0, 0, 4, 2, 7};
    run_win(4, 1'b0);
    // R3 signed total below lower bound on stage 0
    stim_q = '{-10, -1, 0, 5, 0, 1};
    run_win(4, 1'b0);
    // R4 failure on the last stage only
    stim_q = '{-10, 0, 0, 5, 0, -1};
    run_win(4, 1'b0);
    // R2 shorter run-time stage count
    stim_q = '{1, 1, 1, 2, 3};
    run_win(2, 1'b0);
    // R6 zero stages
    run_win(0, 1'b0);
    // R8 start pulsed mid-evaluation is ignored
    stim_q = '{5, -3, 8, 2, 3, 100};
    run_win(4, 1'b1);

    // R10 fill the list with zero-stage windows
    for (int i = 0; i < 4; i++) run_win(0, 1'b0);
    chk(res_count_o == 4'(DEPTH), "R10 full count", res_count_o, DEPTH);
    chk(res_ovf_o == 1'b0, "R10 no ovf at full", res_ovf_o, 0);
    for (int i = 0; i < 2; i++) run_win(0, 1'b0);
    chk(res_count_o == 4'(DEPTH), "R10 count held", res_count_o, DEPTH);
    chk(res_ovf_o == 1'b1, "R10 ovf set", res_ovf_o, 1);

    // R9 read back stored indices
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      res_raddr_i = 3'(i);
      @(negedge clk);
      chk(res_rdata_o == 12'(exp_list[i]), "R9 list entry", res_rdata_o, exp_list[i]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule